// File: doc/BRIEF.md
# Banked UART Register Interface

This block is the byte-wide, memory-mapped register front end of a 16550-style serial port. A host addresses it through a 3-bit offset with separate read and write strobes. The block steers each access to local storage (line control, modem control, interrupt enable, scratch and the 16-bit baud divisor) or to neighbouring logic through single-cycle strobes: a receive-FIFO pop, a transmit-FIFO push and a FIFO-control load. The line status and modem status registers are read-only views assembled from inputs.

Bit 7 of the line control register is a bank select. When it is set, offsets 0 and 1 reach the low and high bytes of the baud divisor instead of the data path and the interrupt-enable register. Offset 2 is asymmetric: a read returns the interrupt identification supplied by the interrupt logic, and a write loads FIFO control. This holds in either bank. Read data is combinational and is valid in the same cycle as the read strobe. Writes take effect at the next rising clock edge.

Four error flags in the line status register (overrun, parity, framing, break) are sticky. A read of that register clears them. The other status bits come straight from the inputs.

Top module: `uart_regif`

## Requirements
- R1: After reset, IER, LCR, MCR, scratch and the divisor are all 0. With thre_i=1, temt_i=1 and the other status inputs at 0, a read of LSR returns 0x60.
- R2: With LCR bit 7 clear, a write to offset 0 raises tx_push_o for that cycle with tx_data_o equal to the written byte. A read of offset 0 raises rx_pop_o for that cycle and returns rx_data_i.
- R3: With LCR bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. divisor_o is {high, low}. No push or pop occurs.
- R4: With LCR bit 7 clear, offset 1 reads and writes IER, and such a write leaves divisor_o unchanged.
- R5: In either bank, a read of offset 2 returns iir_i. A write to offset 2 raises fcr_we_o for one cycle with fcr_o equal to the written byte, and changes no stored register.
- R6: Offsets 3 (LCR), 4 (MCR) and 7 (scratch) read back the last value written, in either bank.
- R7: Writes to offset 5 or 6 change no register and raise no strobe.
- R8: An LSR read returns, from bit 0 upward: rx_ready_i, then the sticky overrun, parity, framing and break flags, then thre_i, temt_i and rx_fifo_err_i. Sticky flags are set by err_set_i bits 0 to 3 respectively.
- R9: An LSR read clears the sticky flags at the next edge. A flag set by err_set_i in the cycle of that read survives.
- R10: A read of offset 6 returns msr_i.
- R11: rx_pop_o, tx_push_o and fcr_we_o are low when no strobe addresses them, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| offset_i | input | 3 | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rd_i |
| rx_data_i | input | 8 | Head byte of receive FIFO |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| tx_data_o | output | 8 | Byte for transmit FIFO |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| iir_i | input | 8 | Interrupt identification from priority logic |
| fcr_o | output | 8 | FIFO control byte |
| fcr_we_o | output | 1 | FIFO control load strobe |
| rx_ready_i | input | 1 | Receive data ready status |
| thre_i | input | 1 | Transmit holding empty status |
| temt_i | input | 1 | Transmitter empty status |
| rx_fifo_err_i | input | 1 | Error present in receive FIFO |
| err_set_i | input | 4 | Set pulses: overrun, parity, framing, break |
| msr_i | input | 8 | Modem status byte |
| ier_o | output | 8 | Interrupt enable register |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| divisor_o | output | 16 | Baud divisor |

## Verification
The assertions assume that the host never raises rd_i and wr_i in the same cycle, and one property checks this assumption. The assertions also treat the status inputs as free-running, so the properties about the sticky flags compare against the err_set_i value sampled in the same cycle. The directed stimulus issues one access per task, drives every input on the falling edge and holds each strobe for exactly one rising edge. Error pulses are raised either alone or together with an LSR read, to cover the case where a set and a clear fall in the same cycle.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

   typedef enum logic [2:0] {
      OFS_DATA  = 3'd0,
      OFS_IER   = 3'd1,
      OFS_IDENT = 3'd2,
      OFS_LCR   = 3'd3,
      OFS_MCR   = 3'd4,
      OFS_LSR   = 3'd5,
      OFS_MSR   = 3'd6,
      OFS_SCR   = 3'd7
   } reg_ofs_e;

   // one-hot address hit after bank selection
   typedef struct packed {
      logic data;
      logic div_lo;
      logic div_hi;
      logic ier;
      logic ident;
      logic lcr;
      logic mcr;
      logic lsr;
      logic msr;
      logic scr;
   } reg_hit_t;

   localparam int unsigned ERR_FLAGS = 4;

endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
   import uart_regif_pkg::*;
(
   input  logic [2:0] offset_i,
   input  logic       bank_i,
   output reg_hit_t   hit_o
);
   always_comb begin
      hit_o = '0;
      unique case (reg_ofs_e'(offset_i))
         OFS_DATA:  if (bank_i) hit_o.div_lo = 1'b1; else hit_o.data = 1'b1;
         OFS_IER:   if (bank_i) hit_o.div_hi = 1'b1; else hit_o.ier  = 1'b1;
         OFS_IDENT: hit_o.ident = 1'b1;
         OFS_LCR:   hit_o.lcr   = 1'b1;
         OFS_MCR:   hit_o.mcr   = 1'b1;
         OFS_LSR:   hit_o.lsr   = 1'b1;
         OFS_MSR:   hit_o.msr   = 1'b1;
         OFS_SCR:   hit_o.scr   = 1'b1;
         default:   hit_o = '0;
      endcase
   end
endmodule

// File: rtl/uart_regif_regs.sv
module uart_regif_regs #(
   parameter int unsigned DATA_W      = 8,
   parameter bit          HAS_SCRATCH = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              sel_ier_i,
   input  logic              sel_lcr_i,
   input  logic              sel_mcr_i,
   input  logic              sel_dlo_i,
   input  logic              sel_dhi_i,
   input  logic              sel_scr_i,
   output logic [DATA_W-1:0] ier_o,
   output logic [DATA_W-1:0] lcr_o,
   output logic [DATA_W-1:0] mcr_o,
   output logic [DATA_W-1:0] dlo_o,
   output logic [DATA_W-1:0] dhi_o,
   output logic [DATA_W-1:0] scr_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ier_o <= '0;
         lcr_o <= '0;
         mcr_o <= '0;
         dlo_o <= '0;
         dhi_o <= '0;
      end else if (wr_i) begin
         if (sel_ier_i) ier_o <= wdata_i;
         if (sel_lcr_i) lcr_o <= wdata_i;
         if (sel_mcr_i) mcr_o <= wdata_i;
         if (sel_dlo_i) dlo_o <= wdata_i;
         if (sel_dhi_i) dhi_o <= wdata_i;
      end
   end

   generate
      if (HAS_SCRATCH) begin : g_scratch
         logic [DATA_W-1:0] scr_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)                 scr_q <= '0;
            else if (wr_i && sel_scr_i)  scr_q <= wdata_i;
         end
         assign scr_o = scr_q;
      end else begin : g_no_scratch
         assign scr_o = '0;
      end
   endgenerate
endmodule

// File: rtl/uart_regif_lsr.sv
module uart_regif_lsr #(
   parameter int unsigned ERR_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ERR_W-1:0] set_i,
   input  logic             clr_i,
   output logic [ERR_W-1:0] err_o
);
   // a set in the clearing cycle wins, so no event is lost
   for (genvar g = 0; g < ERR_W; g++) begin : g_flag
      always_ff @(posedge clk_i) begin
         if (!rst_ni)        err_o[g] <= 1'b0;
         else if (set_i[g])  err_o[g] <= 1'b1;
         else if (clr_i)     err_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
   import uart_regif_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BANK_BIT    = 7,
   parameter bit          HAS_SCRATCH = 1'b1,
   localparam int unsigned DIV_W      = 2 * DATA_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [2:0]           offset_i,
   input  logic                 rd_i,
   input  logic                 wr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   input  logic [DATA_W-1:0]    rx_data_i,
   output logic                 rx_pop_o,
   output logic [DATA_W-1:0]    tx_data_o,
   output logic                 tx_push_o,
   input  logic [DATA_W-1:0]    iir_i,
   output logic [DATA_W-1:0]    fcr_o,
   output logic                 fcr_we_o,
   input  logic                 rx_ready_i,
   input  logic                 thre_i,
   input  logic                 temt_i,
   input  logic                 rx_fifo_err_i,
   input  logic [ERR_FLAGS-1:0] err_set_i,
   input  logic [DATA_W-1:0]    msr_i,
   output logic [DATA_W-1:0]    ier_o,
   output logic [DATA_W-1:0]    lcr_o,
   output logic [DATA_W-1:0]    mcr_o,
   output logic [DIV_W-1:0]     divisor_o
);
   generate
      if (DATA_W < 8) begin : g_chk_width
         $error("uart_regif: DATA_W must be at least 8");
      end
      if (BANK_BIT >= DATA_W) begin : g_chk_bank
         $error("uart_regif: BANK_BIT outside LCR");
      end
   endgenerate

   reg_hit_t              hit;
   logic [DATA_W-1:0]     scr, dlo, dhi;
   logic [ERR_FLAGS-1:0]  lsr_err;
   logic [DATA_W-1:0]     lsr_view;

   uart_regif_decode u_decode (
      .offset_i (offset_i),
      .bank_i   (lcr_o[BANK_BIT]),
      .hit_o    (hit)
   );

   uart_regif_regs #(.DATA_W(DATA_W), .HAS_SCRATCH(HAS_SCRATCH)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_i),
      .wdata_i   (wdata_i),
      .sel_ier_i (hit.ier),
      .sel_lcr_i (hit.lcr),
      .sel_mcr_i (hit.mcr),
      .sel_dlo_i (hit.div_lo),
      .sel_dhi_i (hit.div_hi),
      .sel_scr_i (hit.scr),
      .ier_o     (ier_o),
      .lcr_o     (lcr_o),
      .mcr_o     (mcr_o),
      .dlo_o     (dlo),
      .dhi_o     (dhi),
      .scr_o     (scr)
   );

   uart_regif_lsr #(.ERR_W(ERR_FLAGS)) u_lsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_set_i),
      .clr_i  (rd_i & hit.lsr),
      .err_o  (lsr_err)
   );

   assign lsr_view  = DATA_W'({rx_fifo_err_i, temt_i, thre_i, lsr_err, rx_ready_i});
   assign divisor_o = {dhi, dlo};
   assign tx_data_o = wdata_i;
   assign fcr_o     = wdata_i;
   assign tx_push_o = wr_i & hit.data;
   assign rx_pop_o  = rd_i & hit.data;
   assign fcr_we_o  = wr_i & hit.ident;

   // AND-OR read mux over the one-hot hit vector
   always_comb begin
      rdata_o = ({DATA_W{hit.data}}   & rx_data_i)
              | ({DATA_W{hit.div_lo}} & dlo)
              | ({DATA_W{hit.div_hi}} & dhi)
              | ({DATA_W{hit.ier}}    & ier_o)
              | ({DATA_W{hit.ident}}  & iir_i)
              | ({DATA_W{hit.lcr}}    & lcr_o)
              | ({DATA_W{hit.mcr}}    & mcr_o)
              | ({DATA_W{hit.lsr}}    & lsr_view)
              | ({DATA_W{hit.msr}}    & msr_i)
              | ({DATA_W{hit.scr}}    & scr);
   end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BANK_BIT = 7
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [2:0]          offset_i,
   input logic                rd_i,
   input logic                wr_i,
   input logic [DATA_W-1:0]   wdata_i,
   input logic                rx_pop_o,
   input logic                tx_push_o,
   input logic                fcr_we_o,
   input logic [3:0]          err_set_i,
   input logic [3:0]          lsr_err,
   input logic [DATA_W-1:0]   ier_o,
   input logic [DATA_W-1:0]   lcr_o,
   input logic [DATA_W-1:0]   mcr_o,
   input logic [2*DATA_W-1:0] divisor_o
);
   // environment rule: reads and writes never overlap
   assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_i && wr_i));

   assert_pop_only_on_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_pop_o |-> (rd_i && offset_i == 3'd0 && !lcr_o[BANK_BIT]));

   assert_div_low_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && offset_i == 3'd0 && lcr_o[BANK_BIT])
         |=> (divisor_o[DATA_W-1:0] == $past(wdata_i) && $stable(ier_o)));

   assert_ier_keeps_divisor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && offset_i == 3'd1 && !lcr_o[BANK_BIT])
         |=> ($stable(divisor_o) && ier_o == $past(wdata_i)));

   assert_status_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && (offset_i == 3'd5 || offset_i == 3'd6))
         |=> ($stable(divisor_o) && $stable(ier_o) && $stable(lcr_o) && $stable(mcr_o)));

   assert_lsr_read_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && offset_i == 3'd5) |=> (lsr_err == $past(err_set_i)));

   assert_strobes_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rx_pop_o, tx_push_o, fcr_we_o}));
endmodule

bind uart_regif uart_regif_chk #(.DATA_W(DATA_W), .BANK_BIT(BANK_BIT)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .offset_i  (offset_i),
   .rd_i      (rd_i),
   .wr_i      (wr_i),
   .wdata_i   (wdata_i),
   .rx_pop_o  (rx_pop_o),
   .tx_push_o (tx_push_o),
   .fcr_we_o  (fcr_we_o),
   .err_set_i (err_set_i),
   .lsr_err   (lsr_err),
   .ier_o     (ier_o),
   .lcr_o     (lcr_o),
   .mcr_o     (mcr_o),
   .divisor_o (divisor_o)
);

// File: tb/test_uart_regif.sv
`timescale 1ns/1ps
module test_uart_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  offset = '0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [7:0]  wdata = '0, rdata;
   logic [7:0]  rx_data = 8'hA5, tx_data, iir = 8'hC1, fcr, msr = 8'h00;
   logic        rx_pop, tx_push, fcr_we;
   logic        rx_ready = 1'b0, thre = 1'b1, temt = 1'b1, rx_fifo_err = 1'b0;
   logic [3:0]  err_set = '0;
   logic [7:0]  ier, lcr, mcr;
   logic [15:0] divisor;

   int n_checks = 0, n_fail = 0;

   always #5 clk = ~clk;

   uart_regif i_uart_regif (
      .clk_i(clk), .rst_ni(rst_n), .offset_i(offset), .rd_i(rd), .wr_i(wr),
      .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data), .rx_pop_o(rx_pop),
      .tx_data_o(tx_data), .tx_push_o(tx_push), .iir_i(iir), .fcr_o(fcr),
      .fcr_we_o(fcr_we), .rx_ready_i(rx_ready), .thre_i(thre), .temt_i(temt),
      .rx_fifo_err_i(rx_fifo_err), .err_set_i(err_set), .msr_i(msr),
      .ier_o(ier), .lcr_o(lcr), .mcr_o(mcr), .divisor_o(divisor)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one write: strobe held across exactly one rising edge
   task automatic wr_reg(input logic [2:0] ofs, input logic [7:0] d,
                         output logic push, output logic fwe);
      @(negedge clk);
      offset = ofs; wdata = d; wr = 1'b1;
      #1;
      push = tx_push; fwe = fcr_we;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] ofs, output logic [7:0] d, output logic pop);
      @(negedge clk);
      offset = ofs; rd = 1'b1;
      #1;
      d = rdata; pop = rx_pop;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d; logic p;
      check("R1 ier", ier, 0); check("R1 lcr", lcr, 0);
      check("R1 mcr", mcr, 0); check("R1 divisor", divisor, 0);
      rd_reg(3'd7, d, p); check("R1 scratch", d, 8'h00);
      rd_reg(3'd5, d, p); check("R1 lsr", d, 8'h60);
   endtask

   task automatic t_data_path;
      logic [7:0] d; logic p, f;
      wr_reg(3'd0, 8'h3C, p, f);
      check("R2 push", p, 1); check("R2 tx_data", tx_data, 8'h3C);
      rd_reg(3'd0, d, p);
      check("R2 pop", p, 1); check("R2 rx read", d, 8'hA5);
      check("R2 divisor untouched", divisor, 0);
   endtask

   task automatic t_divisor;
      logic [7:0] d; logic p, f;
      wr_reg(3'd3, 8'h83, p, f); check("R6 lcr bank on", lcr, 8'h83);
      wr_reg(3'd0, 8'h34, p, f); check("R3 no push in bank", p, 0);
      wr_reg(3'd1, 8'h12, p, f);
      check("R3 divisor", divisor, 16'h1234); check("R3 ier kept", ier, 0);
      rd_reg(3'd0, d, p); check("R3 low read", d, 8'h34); check("R3 no pop", p, 0);
      rd_reg(3'd1, d, p); check("R3 high read", d, 8'h12);
   endtask

   task automatic t_ier;
      logic [7:0] d; logic p, f;
      wr_reg(3'd3, 8'h03, p, f); check("R6 lcr bank off", lcr, 8'h03);
      wr_reg(3'd1, 8'h0F, p, f);
      check("R4 ier", ier, 8'h0F); check("R4 divisor kept", divisor, 16'h1234);
      rd_reg(3'd1, d, p); check("R4 ier read", d, 8'h0F);
   endtask

   task automatic t_ident;
      logic [7:0] d; logic p, f;
      rd_reg(3'd2, d, p); check("R5 iir bank0", d, 8'hC1);
      wr_reg(3'd2, 8'h07, p, f);
      check("R5 fcr strobe", f, 1); check("R5 fcr data", fcr, 8'h07);
      check("R5 no push", p, 0);
      wr_reg(3'd3, 8'h80, p, f);
      rd_reg(3'd2, d, p); check("R5 iir bank1", d, 8'hC1);
      wr_reg(3'd2, 8'hC1, p, f); check("R5 fcr strobe bank1", f, 1);
      check("R5 divisor kept", divisor, 16'h1234);
   endtask

   task automatic t_rw_both_banks;
      logic [7:0] d; logic p, f;
      wr_reg(3'd4, 8'h1B, p, f); wr_reg(3'd7, 8'h5A, p, f);
      rd_reg(3'd4, d, p); check("R6 mcr bank1", d, 8'h1B);
      rd_reg(3'd7, d, p); check("R6 scr bank1", d, 8'h5A);
      wr_reg(3'd3, 8'h1F, p, f);
      wr_reg(3'd4, 8'h02, p, f); wr_reg(3'd7, 8'hE7, p, f);
      check("R6 mcr bank0", mcr, 8'h02);
      rd_reg(3'd7, d, p); check("R6 scr bank0", d, 8'hE7);
      rd_reg(3'd3, d, p); check("R6 lcr read", d, 8'h1F);
   endtask

   task automatic t_status_writes;
      logic [7:0] d; logic p, f;
      wr_reg(3'd5, 8'hFF, p, f); check("R7 no strobe lsr", {p, f}, 0);
      wr_reg(3'd6, 8'hFF, p, f); check("R7 no strobe msr", {p, f}, 0);
      check("R7 regs", {ier, lcr, mcr, divisor}, {8'h0F, 8'h1F, 8'h02, 16'h1234});
      rd_reg(3'd5, d, p); check("R7 lsr unchanged", d, 8'h60);
      rd_reg(3'd7, d, p); check("R7 scr unchanged", d, 8'hE7);
   endtask

   task automatic t_lsr;
      logic [7:0] d; logic p;
      @(negedge clk); err_set = 4'b1010; @(negedge clk); err_set = 4'b0000;
      rx_ready = 1'b1; thre = 1'b0; rx_fifo_err = 1'b1;
      rd_reg(3'd5, d, p); check("R8 lsr layout", d, 8'b1101_0101);
      rd_reg(3'd5, d, p); check("R9 cleared", d, 8'b1100_0001);
      // set in the same cycle as a clearing read survives
      @(negedge clk); err_set = 4'b0001; offset = 3'd5; rd = 1'b1;
      @(negedge clk); err_set = 4'b0000; rd = 1'b0;
      rd_reg(3'd5, d, p); check("R9 set wins", d, 8'b1100_0011);
      rx_ready = 1'b0; thre = 1'b1; rx_fifo_err = 1'b0;
      rd_reg(3'd5, d, p); check("R8 live bits", d, 8'h60);
   endtask

   task automatic t_msr;
      logic [7:0] d; logic p;
      msr = 8'hB3;
      rd_reg(3'd6, d, p); check("R10 msr", d, 8'hB3);
      msr = 8'h4C;
      rd_reg(3'd6, d, p); check("R10 msr follows", d, 8'h4C);
   endtask

   task automatic t_idle;
      @(negedge clk); offset = 3'd0; #1;
      check("R11 idle strobes", {rx_pop, tx_push, fcr_we}, 3'b000);
      offset = 3'd2; #1;
      check("R11 idle fcr", fcr_we, 0);
   endtask

   initial begin
      #1_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data_path();
      t_divisor();
      t_ier();
      t_ident();
      t_rw_both_banks();
      t_status_writes();
      t_lsr();
      t_msr();
      t_idle();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule